// File: doc/BRIEF.md
# Motion-Adaptive Field Deinterlacer

The block turns a sequence of interlaced video fields into full double-height frames. Each incoming field carries a parity bit, is streamed in one pixel per valid cycle with start-of-field and start-of-line strobes, and is kept in a small on-chip history. A field-end strobe starts the readout. The block then emits the whole double-height frame in row-major order, one pixel per cycle.

Rows that match the field's parity are copied through. The rows of the other parity are rebuilt in one of two ways. Where the picture is still, the block weaves in the pixel from the previous field. Where the picture has changed, it averages the current field's rows above and below.

Motion is taken from two sources, both recorded as each field is written:
- the current field compared with the last field of the same parity;
- the woven field compared with its own predecessor.

The motion mask is widened by one column on each side, so that a dithered moving area switches mode as a whole region.

A bypass mode line-doubles progressive input. An optional persistence stage blends each output frame over the previous presented frame to give a decaying trail.

Top module: `dei_top`

## Requirements
- R1: After reset, busy_o and out_valid_o are low and no output is produced until a field end is received.
- R2: When eof_i is sampled high while idle, busy_o rises on the next cycle. From the cycle after that, exactly 2*H*W pixels are emitted on consecutive cycles, row by row and left to right. out_sof_o marks the first pixel and out_sol_o marks the first pixel of every row.
- R3: A pixel written with sof_i is at line 0, column 0. A pixel written with sol_i starts the next line at column 0. Any other pixel goes to the next column. Output row r with r mod 2 equal to the field parity carries line r/2 of that field.
- R4: If the opposite parity has no history (first field after reset), every missing row r is the per-channel floor of (above + below)/2. Above is row r-1 and below is row r+1, both taken from the current field. At the top or bottom edge, the single existing neighbour row is used for both.
- R5: With history present and no motion in the window, missing row r takes the previous opposite-parity field's line r/2 at the same column.
- R6: When a field pixel is written, it is marked moving if, for any 8-bit channel, the absolute difference from the same position of the last field of the same parity exceeds thr_i. A difference equal to thr_i is not moving. Against a parity with no history, nothing is marked. Motion at either current-field neighbour row forces interpolation.
- R7: Motion recorded for the woven field (against its own predecessor) also forces interpolation of the missing pixel it would supply.
- R8: A missing pixel at column x is interpolated if any motion source is set at column x-1, x or x+1, within the frame.
- R9: If interlaced_i or deint_en_i is low at sof_i, output row r is line r/2 of the received frame with no history use. The end of such a frame discards all history, so the next interlaced field is handled as in R4.
- R10: If phos_en_i is high with eof_i and a previous output frame exists, each channel is floor((new*(256-k) + prev*k)/256). Here k = min(phos_i, 243) and prev is the previously presented pixel at the same position. Every presented pixel becomes the new history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pix_i | input | 24 | Field pixel, R in [23:16], G in [15:8], B in [7:0] |
| pix_valid_i | input | 1 | pix_i carries a pixel |
| sof_i | input | 1 | First pixel of a field |
| sol_i | input | 1 | First pixel of a line |
| parity_i | input | 1 | Field parity, sampled with sof_i |
| interlaced_i | input | 1 | Field is interlaced, sampled with sof_i |
| deint_en_i | input | 1 | Deinterlacing enabled, sampled with sof_i |
| thr_i | input | 8 | Motion threshold per channel |
| eof_i | input | 1 | Field complete, start readout |
| phos_en_i | input | 1 | Persistence enable, sampled with eof_i |
| phos_i | input | 8 | Persistence coefficient in 1/256, sampled with eof_i |
| out_pix_o | output | 24 | Output pixel, same packing as pix_i |
| out_valid_o | output | 1 | out_pix_o valid |
| out_sof_o | output | 1 | First pixel of the output frame |
| out_sol_o | output | 1 | First pixel of an output row |
| busy_o | output | 1 | Readout in progress; input ignored |

## Verification
busy_o is due one cycle after eof_i is sampled. The first output pixel is due one cycle after busy_o rises, and the rest follow on each cycle after that with no gaps. The driver checks busy_o at the falling edge after the field-end edge. For each field it pushes the full expected frame, computed from history, motion and blending rules kept in the bench. The monitor pops one entry on each falling edge where out_valid_o is high, and compares the pixel together with both frame and row flags. After a bounded wait, the driver also checks that nothing is left in the queue.

// File: rtl/dei_pkg.sv
package dei_pkg;

  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } rgb_t;

  typedef enum logic {ST_IDLE, ST_OUT} rd_state_e;

  function automatic logic ch_moved(logic [7:0] a, logic [7:0] b, logic [7:0] thr);
    logic [7:0] d;
    d = (a > b) ? a - b : b - a;
    return d > thr;
  endfunction

  function automatic logic px_moved(rgb_t a, rgb_t b, logic [7:0] thr);
    return ch_moved(a.r, b.r, thr) | ch_moved(a.g, b.g, thr) | ch_moved(a.b, b.b, thr);
  endfunction

  function automatic logic [7:0] ch_avg(logic [7:0] a, logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[8:1];
  endfunction

  function automatic rgb_t px_avg(rgb_t a, rgb_t b);
    rgb_t o;
    o.r = ch_avg(a.r, b.r);
    o.g = ch_avg(a.g, b.g);
    o.b = ch_avg(a.b, b.b);
    return o;
  endfunction

  function automatic logic [7:0] ch_blend(logic [7:0] n, logic [7:0] o, logic [7:0] k);
    logic [16:0] s;
    s = 17'(n) * (17'd256 - 17'(k)) + 17'(o) * 17'(k);
    return s[15:8];
  endfunction

  function automatic rgb_t px_blend(rgb_t n, rgb_t o, logic [7:0] k);
    rgb_t x;
    x.r = ch_blend(n.r, o.r, k);
    x.g = ch_blend(n.g, o.g, k);
    x.b = ch_blend(n.b, o.b, k);
    return x;
  endfunction

endpackage

// File: rtl/dei_field_store.sv
module dei_field_store import dei_pkg::*; #(
  parameter int unsigned W = 8,
  parameter int unsigned H = 4,
  localparam int unsigned XW = $clog2(W),
  localparam int unsigned YW = $clog2(H)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          wr_par_i,
  input  logic [YW-1:0] wr_y_i,
  input  logic [XW-1:0] wr_x_i,
  input  rgb_t          wr_pix_i,
  input  logic [7:0]    thr_i,
  input  logic          done_i,
  input  logic          done_par_i,
  input  logic          clr_hist_i,
  input  logic          rd_par_i,
  input  logic [YW-1:0] rd_ya_i,
  input  logic [YW-1:0] rd_yb_i,
  input  logic [YW-1:0] rd_yw_i,
  input  logic [XW-1:0] rd_x_i,
  output rgb_t          pix_a_o,
  output rgb_t          pix_b_o,
  output rgb_t          pix_w_o,
  output logic          hist_o,
  output logic          mot_o
);

  rgb_t       mem_q [2][H][W];
  logic       mot_q [2][H][W];
  logic [1:0] hist_q;
  logic       opp;
  logic [XW-1:0] col;

  assign opp = ~rd_par_i;

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[wr_par_i][wr_y_i][wr_x_i] <= wr_pix_i;
  end

  // motion vs. last same-parity field, recorded at write time
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      for (int p = 0; p < 2; p++)
        for (int y = 0; y < int'(H); y++)
          for (int x = 0; x < int'(W); x++)
            mot_q[p][y][x] <= 1'b0;
    end else begin
      if (wr_en_i)
        mot_q[wr_par_i][wr_y_i][wr_x_i] <= hist_q[wr_par_i] &
          px_moved(mem_q[wr_par_i][wr_y_i][wr_x_i], wr_pix_i, thr_i);
      if (done_i) begin
        if (clr_hist_i) hist_q <= '0;
        else            hist_q[done_par_i] <= 1'b1;
      end
    end
  end

  assign pix_a_o = mem_q[rd_par_i][rd_ya_i][rd_x_i];
  assign pix_b_o = mem_q[rd_par_i][rd_yb_i][rd_x_i];
  assign pix_w_o = mem_q[opp][rd_yw_i][rd_x_i];
  assign hist_o  = hist_q[opp];

  // both parities' motion, dilated one column each side
  always_comb begin
    mot_o = 1'b0;
    col   = '0;
    for (int d = -1; d <= 1; d++) begin
      if (int'(rd_x_i) + d >= 0 && int'(rd_x_i) + d < int'(W)) begin
        col   = XW'(int'(rd_x_i) + d);
        mot_o = mot_o | mot_q[rd_par_i][rd_ya_i][col] | mot_q[rd_par_i][rd_yb_i][col]
                      | mot_q[opp][rd_yw_i][col];
      end
    end
  end

endmodule

// File: rtl/dei_row_mix.sv
module dei_row_mix import dei_pkg::*; (
  input  logic own_i,
  input  logic bypass_i,
  input  logic hist_i,
  input  logic mot_i,
  input  rgb_t pix_a_i,
  input  rgb_t pix_b_i,
  input  rgb_t pix_w_i,
  output rgb_t pix_o
);

  always_comb begin
    if (own_i || bypass_i)   pix_o = pix_a_i;
    else if (hist_i && !mot_i) pix_o = pix_w_i;
    else                     pix_o = px_avg(pix_a_i, pix_b_i);
  end

endmodule

// File: rtl/dei_persist.sv
module dei_persist import dei_pkg::*; #(
  parameter int unsigned W = 8,
  parameter int unsigned H = 4,
  localparam int unsigned N  = 2 * W * H,
  localparam int unsigned AW = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  input  logic          in_sof_i,
  input  logic          in_sol_i,
  input  logic          in_last_i,
  input  logic [AW-1:0] in_idx_i,
  input  rgb_t          in_pix_i,
  input  logic          blend_en_i,
  input  logic [7:0]    k_i,
  output rgb_t          out_pix_o,
  output logic          out_valid_o,
  output logic          out_sof_o,
  output logic          out_sol_o
);

  rgb_t hist_mem [N];
  logic have_q;
  rgb_t mixed;

  assign mixed = (blend_en_i && have_q) ? px_blend(in_pix_i, hist_mem[in_idx_i], k_i) : in_pix_i;

  always_ff @(posedge clk_i) begin
    if (in_valid_i) hist_mem[in_idx_i] <= mixed;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_pix_o   <= '0;
      out_valid_o <= 1'b0;
      out_sof_o   <= 1'b0;
      out_sol_o   <= 1'b0;
      have_q      <= 1'b0;
    end else begin
      out_valid_o <= in_valid_i;
      out_sof_o   <= in_valid_i & in_sof_i;
      out_sol_o   <= in_valid_i & in_sol_i;
      if (in_valid_i) out_pix_o <= mixed;
      if (in_valid_i && in_last_i) have_q <= 1'b1;
    end
  end

endmodule

// File: rtl/dei_top.sv
module dei_top import dei_pkg::*; #(
  parameter int unsigned W        = 8,
  parameter int unsigned H        = 4,
  parameter logic [7:0]  PHOS_MAX = 8'd243
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [23:0] pix_i,
  input  logic        pix_valid_i,
  input  logic        sof_i,
  input  logic        sol_i,
  input  logic        parity_i,
  input  logic        interlaced_i,
  input  logic        deint_en_i,
  input  logic [7:0]  thr_i,
  input  logic        eof_i,
  input  logic        phos_en_i,
  input  logic [7:0]  phos_i,
  output logic [23:0] out_pix_o,
  output logic        out_valid_o,
  output logic        out_sof_o,
  output logic        out_sol_o,
  output logic        busy_o
);

  localparam int unsigned XW = $clog2(W);
  localparam int unsigned YW = $clog2(H);
  localparam int unsigned RW = YW + 1;
  localparam int unsigned AW = $clog2(2 * W * H);
  localparam logic [XW-1:0] XLAST  = XW'(W - 1);
  localparam logic [RW-1:0] RLAST  = RW'(2 * H - 1);
  localparam logic [YW:0]   YLAST  = (YW + 1)'(H - 1);
  localparam logic [YW:0]   YCNT   = (YW + 1)'(H);
  localparam logic [XW:0]   XCNT   = (XW + 1)'(W);
  localparam logic [YW:0]   Y1     = (YW + 1)'(1);
  localparam logic [XW:0]   X1W    = (XW + 1)'(1);
  localparam logic [XW-1:0] X1     = XW'(1);
  localparam logic [RW-1:0] R1     = RW'(1);
  localparam logic [AW-1:0] A1     = AW'(1);
  localparam logic [YW-1:0] YL1    = YW'(1);

  rd_state_e     state_q;
  logic          idle;
  logic          par_q, byp_q, blend_q;
  logic [7:0]    k_q;
  logic [YW:0]   ly_q, wy;
  logic [XW:0]   lx_q, wx;
  logic          wr_en, wr_par, done;
  logic [RW-1:0] rd_r_q;
  logic [XW-1:0] rd_c_q;
  logic [AW-1:0] rd_i_q;
  logic          rd_last, own;
  logic [YW-1:0] line_lo, rd_ya, rd_yb;
  logic [YW:0]   line_up;
  rgb_t          pix_a, pix_b, pix_w, mix_pix, out_pix;
  logic          hist_w, mot_w;

  assign idle   = (state_q == ST_IDLE);
  assign busy_o = ~idle;

  // write position from strobes
  always_comb begin
    if (sof_i) begin
      wy = '0;
      wx = '0;
    end else if (sol_i) begin
      wy = (&ly_q) ? ly_q : ly_q + Y1;
      wx = '0;
    end else begin
      wy = ly_q;
      wx = (&lx_q) ? lx_q : lx_q + X1W;
    end
  end

  assign wr_en  = idle && pix_valid_i && (wy < YCNT) && (wx < XCNT);
  assign wr_par = sof_i ? parity_i : par_q;
  assign done   = idle && eof_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ly_q  <= '0;
      lx_q  <= '0;
      par_q <= 1'b0;
      byp_q <= 1'b0;
    end else if (idle && pix_valid_i) begin
      ly_q <= wy;
      lx_q <= wx;
      if (sof_i) begin
        par_q <= parity_i;
        byp_q <= ~(interlaced_i & deint_en_i);
      end
    end
  end

  assign rd_last = (rd_r_q == RLAST) && (rd_c_q == XLAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rd_r_q  <= '0;
      rd_c_q  <= '0;
      rd_i_q  <= '0;
      blend_q <= 1'b0;
      k_q     <= '0;
    end else if (idle) begin
      if (eof_i) begin
        state_q <= ST_OUT;
        rd_r_q  <= '0;
        rd_c_q  <= '0;
        rd_i_q  <= '0;
        blend_q <= phos_en_i;
        k_q     <= (phos_i > PHOS_MAX) ? PHOS_MAX : phos_i;
      end
    end else begin
      rd_i_q <= rd_i_q + A1;
      if (rd_c_q == XLAST) begin
        rd_c_q <= '0;
        rd_r_q <= rd_r_q + R1;
      end else begin
        rd_c_q <= rd_c_q + X1;
      end
      if (rd_last) state_q <= ST_IDLE;
    end
  end

  // neighbour rows of the current field, clamped at edges
  assign own     = (rd_r_q[0] == par_q);
  assign line_lo = rd_r_q[RW-1:1];
  assign line_up = {1'b0, line_lo} + Y1;
  assign rd_ya   = (rd_r_q[0] || own || byp_q || line_lo == '0) ? line_lo : line_lo - YL1;
  assign rd_yb   = !rd_r_q[0] ? line_lo :
                   (line_up > YLAST) ? YLAST[YW-1:0] : line_up[YW-1:0];

  dei_field_store #(.W(W), .H(H)) u_store (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .wr_par_i   (wr_par),
    .wr_y_i     (wy[YW-1:0]),
    .wr_x_i     (wx[XW-1:0]),
    .wr_pix_i   (rgb_t'(pix_i)),
    .thr_i      (thr_i),
    .done_i     (done),
    .done_par_i (par_q),
    .clr_hist_i (byp_q),
    .rd_par_i   (par_q),
    .rd_ya_i    (rd_ya),
    .rd_yb_i    (rd_yb),
    .rd_yw_i    (line_lo),
    .rd_x_i     (rd_c_q),
    .pix_a_o    (pix_a),
    .pix_b_o    (pix_b),
    .pix_w_o    (pix_w),
    .hist_o     (hist_w),
    .mot_o      (mot_w)
  );

  dei_row_mix u_mix (
    .own_i    (own),
    .bypass_i (byp_q),
    .hist_i   (hist_w),
    .mot_i    (mot_w),
    .pix_a_i  (pix_a),
    .pix_b_i  (pix_b),
    .pix_w_i  (pix_w),
    .pix_o    (mix_pix)
  );

  dei_persist #(.W(W), .H(H)) u_persist (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .in_valid_i  (~idle),
    .in_sof_i    (rd_i_q == '0),
    .in_sol_i    (rd_c_q == '0),
    .in_last_i   (rd_last),
    .in_idx_i    (rd_i_q),
    .in_pix_i    (mix_pix),
    .blend_en_i  (blend_q),
    .k_i         (k_q),
    .out_pix_o   (out_pix),
    .out_valid_o (out_valid_o),
    .out_sof_o   (out_sof_o),
    .out_sol_o   (out_sol_o)
  );

  assign out_pix_o = out_pix;

endmodule

// File: rtl/dei_top_chk.sv
module dei_top_chk #(
  parameter int unsigned W = 8
) (
  input logic clk_i,
  input logic rst_ni,
  input logic eof_i,
  input logic busy_o,
  input logic out_valid_o,
  input logic out_sof_o,
  input logic out_sol_o
);

  localparam int unsigned CW = $clog2(W) + 1;
  localparam logic [CW-1:0] WCNT = CW'(W);
  localparam logic [CW-1:0] C1   = CW'(1);

  logic [CW-1:0] col_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          col_cnt <= '0;
    else if (out_valid_o) col_cnt <= out_sol_o ? C1 : col_cnt + C1;
  end

  AST_RESET_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !busy_o && !out_valid_o) else $error("reset state"); // R1
  AST_BUSY_FROM_EOF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(eof_i)) else $error("busy without eof"); // R2
  AST_VALID_FROM_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(busy_o)) else $error("output outside readout"); // R2
  AST_SOF_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_sof_o |-> out_sol_o && out_valid_o) else $error("frame flag"); // R2
  AST_ROW_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_sol_o && !out_sof_o |-> col_cnt == WCNT) else $error("row length"); // R2
  AST_ROW_SHORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_sol_o |-> col_cnt != '0 && col_cnt < WCNT) else $error("row overrun"); // R2

endmodule

bind dei_top dei_top_chk #(.W(W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .eof_i       (eof_i),
  .busy_o      (busy_o),
  .out_valid_o (out_valid_o),
  .out_sof_o   (out_sof_o),
  .out_sol_o   (out_sol_o)
);

// File: tb/dei_top_test.sv
module dei_top_test;

  localparam int W = 8;
  localparam int H = 4;
  localparam int R = 2 * H;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [23:0] pix;
  logic        pix_valid, sof, sol, parity, lace, den, eof, ph_en;
  logic [7:0]  thr, ph;
  logic [23:0] out_pix;
  logic        out_valid, out_sof, out_sol, busy;

  dei_top #(.W(W), .H(H)) uut (
    .clk_i(clk), .rst_ni(rst_n), .pix_i(pix), .pix_valid_i(pix_valid),
    .sof_i(sof), .sol_i(sol), .parity_i(parity), .interlaced_i(lace),
    .deint_en_i(den), .thr_i(thr), .eof_i(eof), .phos_en_i(ph_en), .phos_i(ph),
    .out_pix_o(out_pix), .out_valid_o(out_valid), .out_sof_o(out_sof),
    .out_sol_o(out_sol), .busy_o(busy)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [25:0] exp_q[$];
  string       tag_q[$];

  logic [23:0] img   [H][W];
  logic [23:0] m_buf [2][H][W];
  bit          m_mot [2][H][W];
  bit          m_hv  [2];
  logic [23:0] m_out [R][W];
  bit          m_pv;
  bit          m_after_byp;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit moved(logic [23:0] a, logic [23:0] b, logic [7:0] t);
    bit m = 0;
    for (int s = 0; s < 3; s++) begin
      int d;
      d = int'(a[s*8 +: 8]) - int'(b[s*8 +: 8]);
      if (d < 0) d = -d;
      if (d > int'(t)) m = 1;
    end
    return m;
  endfunction

  function automatic logic [23:0] avg(logic [23:0] a, logic [23:0] b);
    logic [23:0] o;
    for (int s = 0; s < 3; s++) o[s*8 +: 8] = 8'((int'(a[s*8 +: 8]) + int'(b[s*8 +: 8])) / 2);
    return o;
  endfunction

  function automatic logic [23:0] blend(logic [23:0] n, logic [23:0] p, int k);
    logic [23:0] o;
    for (int s = 0; s < 3; s++)
      o[s*8 +: 8] = 8'((int'(n[s*8 +: 8]) * (256 - k) + int'(p[s*8 +: 8]) * k) / 256);
    return o;
  endfunction

  function automatic logic [23:0] pat(int kind, int y, int x);
    if (kind == 0) return {8'(y * 40 + x * 3 + 5), 8'(x * 25 + 10), 8'(200 - y * 20 - x)};
    if (kind == 1) return {8'(y * 40 + x * 3 + 100), 8'(x * 25 + 60), 8'(y * 11 + x * 7)};
    return {8'(x * 30 + 1), 8'(y * 50 + 2), 8'(x * y + 3)};
  endfunction

  task automatic load_img(input int kind);
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++)
        img[y][x] = pat(kind, y, x);
  endtask

  // model from requirements, then drive the field
  task automatic run_field(input bit p, input bit il, input bit en, input logic [7:0] t,
                           input bit pe, input logic [7:0] pc);
    bit byp;
    int k;
    int q;
    byp = !(il && en);
    k = (pc > 8'd243) ? 243 : int'(pc);
    q = 1 - int'(p);
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) begin
        m_mot[p][y][x] = m_hv[p] && moved(m_buf[p][y][x], img[y][x], t);
        m_buf[p][y][x] = img[y][x];
      end
    for (int r = 0; r < R; r++)
      for (int c = 0; c < W; c++) begin
        logic [23:0] e;
        string tg;
        if (byp) begin
          e = m_buf[p][r / 2][c]; tg = "R9";
        end else if ((r % 2) == int'(p)) begin
          e = m_buf[p][r / 2][c]; tg = "R3";
        end else begin
          int ra, rb, ya, yb, yw;
          bit mc, mw, md;
          ra = (r > 0) ? r - 1 : r + 1;
          rb = (r < R - 1) ? r + 1 : r - 1;
          ya = ra / 2; yb = rb / 2; yw = r / 2;
          mc = m_mot[p][ya][c] || m_mot[p][yb][c];
          mw = m_mot[q][yw][c];
          md = 0;
          for (int d = -1; d <= 1; d++)
            if (c + d >= 0 && c + d < W)
              md = md | m_mot[p][ya][c + d] | m_mot[p][yb][c + d] | m_mot[q][yw][c + d];
          if (!m_hv[q]) begin
            e = avg(m_buf[p][ya][c], m_buf[p][yb][c]); tg = m_after_byp ? "R9" : "R4";
          end else if (!md) begin
            e = m_buf[q][yw][c]; tg = "R5";
          end else begin
            e = avg(m_buf[p][ya][c], m_buf[p][yb][c]);
            tg = mc ? "R6" : (mw ? "R7" : "R8");
          end
        end
        if (pe && m_pv) begin
          e = blend(e, m_out[r][c], k); tg = "R10";
        end
        m_out[r][c] = e;
        exp_q.push_back({e, (r == 0 && c == 0), (c == 0)});
        tag_q.push_back(tg);
      end
    m_pv = 1;
    if (byp) begin
      m_hv[0] = 0; m_hv[1] = 0; m_after_byp = 1;
    end else begin
      m_hv[p] = 1; m_after_byp = 0;
    end
    thr = t; lace = il; den = en; parity = p;
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) begin
        @(negedge clk);
        pix_valid = 1; sof = (y == 0 && x == 0); sol = (x == 0); pix = img[y][x];
      end
    @(negedge clk);
    pix_valid = 0; sof = 0; sol = 0; eof = 1; ph_en = pe; ph = pc;
    @(negedge clk);
    eof = 0;
    chk(busy == 1'b1, "R2 busy after eof", 32'(busy), 32'd1);
    for (int i = 0; i < 4 * W * H + 8; i++) @(negedge clk);
    chk(exp_q.size() == 0, "R2 frame length", 32'(exp_q.size()), 32'd0);
    exp_q.delete();
    tag_q.delete();
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) begin
        chk(0, "R2 extra output", {6'd0, out_pix, out_sof, out_sol}, 32'd0);
      end else begin
        logic [25:0] e;
        string tg;
        e = exp_q.pop_front();
        tg = tag_q.pop_front();
        chk({out_pix, out_sof, out_sol} == e, tg, {6'd0, out_pix, out_sof, out_sol}, {6'd0, e});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    pix = '0; pix_valid = 0; sof = 0; sol = 0; parity = 0; lace = 1; den = 1;
    thr = 8'd10; eof = 0; ph_en = 0; ph = '0;
    m_hv[0] = 0; m_hv[1] = 0; m_pv = 0; m_after_byp = 0;
    for (int p = 0; p < 2; p++)
      for (int y = 0; y < H; y++)
        for (int x = 0; x < W; x++) begin
          m_buf[p][y][x] = '0; m_mot[p][y][x] = 0;
        end
    repeat (3) @(negedge clk);
    chk(!out_valid && !busy, "R1 in reset", {30'd0, out_valid, busy}, 32'd0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk(!out_valid && !busy, "R1 after reset", {30'd0, out_valid, busy}, 32'd0);

    // R4: first field, no history
    load_img(0); run_field(0, 1, 1, 8'd10, 0, 8'd0);
    // R5: static weaves
    load_img(1); run_field(1, 1, 1, 8'd10, 0, 8'd0);
    load_img(0); run_field(0, 1, 1, 8'd10, 0, 8'd0);
    // R6, R8: one moving pixel in current field
    load_img(1); img[1][3] = 24'hF0_0F_F0; run_field(1, 1, 1, 8'd10, 0, 8'd0);
    // R7: woven field carries motion
    load_img(0); run_field(0, 1, 1, 8'd10, 0, 8'd0);
    // R6 threshold: equal is static, one above is moving
    load_img(1); img[1][3] = 24'hF0_0F_F0;
    img[2][5][15:8] = img[2][5][15:8] + 8'd10;
    img[0][0][23:16] = img[0][0][23:16] + 8'd11;
    run_field(1, 1, 1, 8'd10, 0, 8'd0);
    // R9: progressive frame, then history cleared
    load_img(2); run_field(0, 0, 1, 8'd10, 0, 8'd0);
    load_img(1); run_field(1, 1, 1, 8'd10, 0, 8'd0);
    load_img(0); run_field(0, 1, 0, 8'd10, 0, 8'd0);
    // R10: persistence, then clamp at 243
    load_img(1); run_field(1, 1, 1, 8'd10, 1, 8'd200);
    load_img(0); run_field(0, 1, 1, 8'd10, 1, 8'd255);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule